// File: doc/BRIEF.md
# Teletext Data Request Timing Generator

This block sits beside the line and field counters of a video encoder and tells an external teletext data source when to deliver bits. On every video line that lies inside a programmed line window for the current field, it drives a request strobe high. The strobe starts at a programmable horizontal position and lasts for a fixed number of pixel clocks. A programmable number of clocks after each request rising edge, it gives a one-cycle sampling enable that marks the cycle in which the returned data is expected to be valid.

Each field parity has its own window, set by a first-line and a last-line register field. Line numbers count from 0 at the first field synchronization pulse. The raw register values are shifted by fixed offsets, and the offsets differ between 525-line and 625-line systems and between the first and the last line. A format select sets the length of the request strobe. The block has no other effect on the video path.

Top module: `ttx_req_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ttx_req`, `data_valid` and `line_active` are all 0 in the cycle that follows.
- R2: With `sys525` = 0 (625-line system), the window of a field runs from line (first field + 1) to line (last field), with both ends included. `line_active` is registered: in the cycle after an edge it shows whether the `vcount` sampled at that edge lies in the window of the current field.
- R3: With `sys525` = 1 (525-line system), the window runs from line (first field + 4) to line (last field + 3), with both ends included.
- R4: With `field_odd` = 1, the odd-field fields (`odd_first`, `odd_last`) set the window. With `field_odd` = 0, the even-field fields (`even_first`, `even_last`) set it.
- R5: When the offset first line is greater than the offset last line, no line of that field is in the window. `line_active` stays 0 and no request is issued in that field.
- R6: When `hcount` equals `h_start` at a clock edge, `vcount` lies in the current window and `ttx_req` is low, `ttx_req` is 1 in the following cycle. No request begins on a line outside the window.
- R7: A request stays high for exactly LEN_STD cycles when `fmt_wst` = 0 (NABTS or European teletext) or LEN_WST cycles when `fmt_wst` = 1 (60 Hz world-standard teletext). The format is the one present at the edge where the request starts.
- R8: `data_valid` is a single-cycle pulse D cycles after the first cycle of each request, where D = `dv_delay` if `dv_delay` ≥ 2 and D = 2 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hcount | input | HCNT_W | Pixel position within the line |
| vcount | input | VCNT_W | Line number, 0 at the first field sync pulse |
| field_odd | input | 1 | 1 = odd field, 0 = even field |
| sys525 | input | 1 | 1 = 525-line system, 0 = 625-line system |
| fmt_wst | input | 1 | 0 = NABTS/European format, 1 = 60 Hz world-standard format |
| h_start | input | HCNT_W | Horizontal position at which the request begins |
| dv_delay | input | DLY_W | Request-to-data delay in clocks (minimum 2 applied) |
| odd_first | input | LREG_W | First-line field, odd field |
| odd_last | input | LREG_W | Last-line field, odd field |
| even_first | input | LREG_W | First-line field, even field |
| even_last | input | LREG_W | Last-line field, even field |
| ttx_req | output | 1 | Teletext data request strobe |
| data_valid | output | 1 | One-cycle data sampling enable |
| line_active | output | 1 | Current line lies in the request window |

## Verification
A request rising edge and the sampling enable of that same request can never coincide. With the clamped minimum delay of 2, however, the sampling enable falls while the strobe is still high, and it also falls near the moments when the window boundary changes at a line wrap. The bench programs `dv_delay` to 0, 1, 2 and 15 and places one-line windows and windows that touch the field edges. A behavioural model compares `ttx_req`, `data_valid` and `line_active` on every cycle, so an overlap that is handled wrongly shows up as a mismatch in the exact cycle where it occurs.

// File: rtl/ttx_pkg.sv
// Package: shared constants for the teletext request generator.
// Holds the line offsets that turn raw window fields into line numbers,
// and the format select encoding.
package ttx_pkg;

    // Offsets added to the first/last window fields, by line system.
    localparam int unsigned OFS_FIRST_525 = 4;
    localparam int unsigned OFS_LAST_525  = 3;
    localparam int unsigned OFS_FIRST_625 = 1;
    localparam int unsigned OFS_LAST_625  = 0;

    // Request format select.
    typedef enum logic {
        FMT_STD = 1'b0,   // NABTS or European teletext
        FMT_WST = 1'b1    // 60 Hz world-standard teletext
    } ttx_fmt_e;

endpackage

// File: rtl/ttx_line_window.sv
// Module: ttx_line_window
// Works out whether the current line lies inside the request window of the
// current field parity. Both parities are compared in parallel and the result
// of the parity in use is selected. Both window ends are inclusive.
// Assumes: vcount counts from 0 at the first field sync pulse. The window
// fields are stable for a whole field.
module ttx_line_window
    import ttx_pkg::*;
#(
    parameter int VCNT_W = 10,
    parameter int LREG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VCNT_W-1:0] vcount,
    input  logic              field_odd,
    input  logic              sys525,
    input  logic [LREG_W-1:0] odd_first,
    input  logic [LREG_W-1:0] odd_last,
    input  logic [LREG_W-1:0] even_first,
    input  logic [LREG_W-1:0] even_last,
    output logic              win_now,
    output logic              win_q
);

    localparam int SUM_W = ((LREG_W > VCNT_W) ? LREG_W : VCNT_W) + 1;

    logic [LREG_W-1:0] first_cfg [2];
    logic [LREG_W-1:0] last_cfg  [2];
    logic [SUM_W-1:0]  lo_line   [2];
    logic [SUM_W-1:0]  hi_line   [2];
    logic [1:0]        hit;
    logic [SUM_W-1:0]  line_ext;
    logic [SUM_W-1:0]  ofs_first;
    logic [SUM_W-1:0]  ofs_last;

    assign first_cfg[0] = even_first;
    assign last_cfg[0]  = even_last;
    assign first_cfg[1] = odd_first;
    assign last_cfg[1]  = odd_last;

    assign line_ext  = SUM_W'(vcount);
    assign ofs_first = sys525 ? SUM_W'(OFS_FIRST_525) : SUM_W'(OFS_FIRST_625);
    assign ofs_last  = sys525 ? SUM_W'(OFS_LAST_525)  : SUM_W'(OFS_LAST_625);

    // One inclusive comparator per field parity (index 1 = odd).
    for (genvar g = 0; g < 2; g++) begin : g_par
        // Offset window bounds and membership test for this parity.
        always_comb begin
            lo_line[g] = SUM_W'(first_cfg[g]) + ofs_first;
            hi_line[g] = SUM_W'(last_cfg[g]) + ofs_last;
            hit[g]     = (line_ext >= lo_line[g]) && (line_ext <= hi_line[g]);
        end
    end

    assign win_now = hit[field_odd];

    // Register the window flag for the line_active output.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= 1'b0;
        else        win_q <= win_now;
    end

    // An inverted window (first above last) never marks a line active.
    assert_empty_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_line[field_odd] > hi_line[field_odd]) |=> !win_q);

endmodule

// File: rtl/ttx_req_pulse.sv
// Module: ttx_req_pulse
// Raises the request strobe when the horizontal count reaches the programmed
// start on a line inside the window. It then holds the strobe for a length
// chosen by the format select at the start of the pulse.
// Assumes: start + length fits inside one line, so one pulse per line.
module ttx_req_pulse
    import ttx_pkg::*;
#(
    parameter int HCNT_W  = 11,
    parameter int LEN_STD = 8,
    parameter int LEN_WST = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCNT_W-1:0] hcount,
    input  logic [HCNT_W-1:0] h_start,
    input  logic              win_now,
    input  logic              fmt_wst,
    output logic              req_o,
    output logic              rise_o
);

    localparam int LEN_MAX = (LEN_STD > LEN_WST) ? LEN_STD : LEN_WST;
    localparam int LEN_W   = $clog2(LEN_MAX + 1);

    ttx_fmt_e          fmt;
    logic [LEN_W-1:0]  len_sel;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  len_l;
    logic [LEN_W-1:0]  hi_run;
    logic              start;

    assign fmt     = ttx_fmt_e'(fmt_wst);
    assign len_sel = (fmt == FMT_WST) ? LEN_W'(LEN_WST) : LEN_W'(LEN_STD);
    assign start   = win_now && (hcount == h_start) && !req_o;

    // Request state: load the length on start, count down while high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o  <= 1'b0;
            rise_o <= 1'b0;
            remain <= '0;
        end else if (req_o) begin
            rise_o <= 1'b0;
            if (remain == '0) req_o  <= 1'b0;
            else              remain <= remain - 1'b1;
        end else begin
            rise_o <= start;
            if (start) begin
                req_o  <= 1'b1;
                remain <= len_sel - 1'b1;
            end
        end
    end

    // Checker state: latched length and run of high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_l  <= '0;
            hi_run <= '0;
        end else if (start) begin
            len_l  <= len_sel;
            hi_run <= LEN_W'(1);
        end else if (req_o && remain != '0) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // A request only begins after a start position seen on a window line.
    assert_rise_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(win_now && (hcount == h_start)));

    // The strobe lasts exactly the length latched at its start.
    assert_req_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> (hi_run == len_l));

endmodule

// File: rtl/ttx_dv_delay.sv
// Module: ttx_dv_delay
// Delays the request rising-edge pulse through a tapped shift line and picks
// the tap given by the programmed delay, with a floor of 2 cycles.
// Assumes: the delay field only changes while no pulse is in flight.
module ttx_dv_delay #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    input  logic [DLY_W-1:0] dly_cfg,
    output logic             dv_o
);

    localparam int MAX_DLY = (1 << DLY_W) - 1;
    localparam int MIN_DLY = 2;
    localparam int CNT_W   = DLY_W + 1;

    logic [MAX_DLY:0] tap;
    logic [DLY_W-1:0] eff;
    logic [CNT_W-1:0] since_rise;

    assign tap[0] = rise_i;
    assign eff    = (dly_cfg < DLY_W'(MIN_DLY)) ? DLY_W'(MIN_DLY) : dly_cfg;
    assign dv_o   = tap[eff];

    // One register per delay stage.
    for (genvar k = 1; k <= MAX_DLY; k++) begin : g_stage
        // Move the pulse one stage further along.
        always_ff @(posedge clk) begin
            if (!rst_n) tap[k] <= 1'b0;
            else        tap[k] <= tap[k-1];
        end
    end

    // Checker state: cycles since the last rise pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rise <= '1;
        else if (rise_i)            since_rise <= CNT_W'(1);
        else if (since_rise != '1)  since_rise <= since_rise + 1'b1;
    end

    // The sampling enable lands exactly the effective delay after a rise.
    assert_dv_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |-> (since_rise == CNT_W'(eff)));

    // The sampling enable is one cycle wide.
    assert_dv_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dv_o |=> !dv_o);

endmodule

// File: rtl/ttx_req_gen.sv
// Module: ttx_req_gen (top)
// Teletext data request timing generator. Combines the per-field line window,
// the request strobe and the delayed data sampling enable.
// Assumes: hcount/vcount come from the encoder's own timing. The register
// fields change only between fields.
module ttx_req_gen #(
    parameter int HCNT_W  = 11,
    parameter int VCNT_W  = 10,
    parameter int LREG_W  = 8,
    parameter int DLY_W   = 4,
    parameter int LEN_STD = 8,
    parameter int LEN_WST = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HCNT_W-1:0] hcount,
    input  logic [VCNT_W-1:0] vcount,
    input  logic              field_odd,
    input  logic              sys525,
    input  logic              fmt_wst,
    input  logic [HCNT_W-1:0] h_start,
    input  logic [DLY_W-1:0]  dv_delay,
    input  logic [LREG_W-1:0] odd_first,
    input  logic [LREG_W-1:0] odd_last,
    input  logic [LREG_W-1:0] even_first,
    input  logic [LREG_W-1:0] even_last,
    output logic              ttx_req,
    output logic              data_valid,
    output logic              line_active
);

    logic win_now;
    logic rise;

    ttx_line_window #(
        .VCNT_W (VCNT_W),
        .LREG_W (LREG_W)
    ) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcount     (vcount),
        .field_odd  (field_odd),
        .sys525     (sys525),
        .odd_first  (odd_first),
        .odd_last   (odd_last),
        .even_first (even_first),
        .even_last  (even_last),
        .win_now    (win_now),
        .win_q      (line_active)
    );

    ttx_req_pulse #(
        .HCNT_W  (HCNT_W),
        .LEN_STD (LEN_STD),
        .LEN_WST (LEN_WST)
    ) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .hcount  (hcount),
        .h_start (h_start),
        .win_now (win_now),
        .fmt_wst (fmt_wst),
        .req_o   (ttx_req),
        .rise_o  (rise)
    );

    ttx_dv_delay #(
        .DLY_W (DLY_W)
    ) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .dly_cfg (dv_delay),
        .dv_o    (data_valid)
    );

    // Reset leaves every output low in the following cycle.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!ttx_req && !data_valid && !line_active));

    // A request never starts on a line that is not in the window.
    assert_no_req_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_now && !ttx_req) |=> !ttx_req);

endmodule

// File: tb/sim_ttx_req_gen.sv
module sim_ttx_req_gen;

    localparam int CLK_PERIOD = 10;
    localparam int HTOT       = 64;
    localparam int NLINES     = 24;
    localparam int LEN_STD    = 8;
    localparam int LEN_WST    = 12;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] hcount;
    logic [9:0]  vcount;
    logic        field_odd;
    logic        sys525;
    logic        fmt_wst;
    logic [10:0] h_start;
    logic [3:0]  dv_delay;
    logic [7:0]  odd_first, odd_last, even_first, even_last;
    logic        ttx_req, data_valid, line_active;

    int checks = 0;
    int fails  = 0;
    string tag_win = "R2";
    string tag_req = "R6";

    // Reference model state.
    bit m_req, m_dv, m_win;
    int m_rem;
    int m_cyc;
    int due[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ttx_req_gen u0 (
        .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
        .field_odd(field_odd), .sys525(sys525), .fmt_wst(fmt_wst),
        .h_start(h_start), .dv_delay(dv_delay),
        .odd_first(odd_first), .odd_last(odd_last),
        .even_first(even_first), .even_last(even_last),
        .ttx_req(ttx_req), .data_valid(data_valid), .line_active(line_active)
    );

    function automatic bit in_window();
        int lo, hi;
        lo = (field_odd ? int'(odd_first) : int'(even_first)) + (sys525 ? 4 : 1);
        hi = (field_odd ? int'(odd_last)  : int'(even_last))  + (sys525 ? 3 : 0);
        return (int'(vcount) >= lo) && (int'(vcount) <= hi);
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit w;
        int d;
        w = in_window();
        m_cyc++;
        if (!rst_n) begin
            m_req = 0; m_dv = 0; m_win = 0; m_rem = 0;
            due.delete();
        end else begin
            m_win = w;
            m_dv  = 0;
            if (due.size() > 0 && due[0] == m_cyc) begin
                m_dv = 1;
                void'(due.pop_front());
            end
            if (m_req) begin
                m_rem--;
                if (m_rem == 0) m_req = 0;
            end else if (w && hcount == h_start) begin
                m_req = 1;
                m_rem = fmt_wst ? LEN_WST : LEN_STD;
                d = (dv_delay < 2) ? 2 : int'(dv_delay);
                due.push_back(m_cyc + d);
            end
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at t=%0t actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk(tag_win, "line_active", line_active, m_win);
        chk(tag_req, "ttx_req", ttx_req, m_req);
        chk("R8", "data_valid", data_valid, m_dv);
    endtask

    task automatic advance();
        if (int'(hcount) == HTOT-1) begin
            hcount <= '0;
            if (int'(vcount) == NLINES-1) begin
                vcount    <= '0;
                field_odd <= ~field_odd;
            end else begin
                vcount <= vcount + 1'b1;
            end
        end else begin
            hcount <= hcount + 1'b1;
        end
    endtask

    task automatic run_phase(string tw, string tr, bit s525, bit fw, int hs, int dly,
                             int of, int ol, int ef, int el);
        tag_win = tw; tag_req = tr;
        sys525 = s525; fmt_wst = fw; h_start = 11'(hs); dv_delay = 4'(dly);
        odd_first = 8'(of); odd_last = 8'(ol); even_first = 8'(ef); even_last = 8'(el);
        repeat (2*NLINES*HTOT) begin
            @(negedge clk);
            compare();
            advance();
        end
    endtask

    initial begin
        rst_n = 0; hcount = '0; vcount = 10'd5; field_odd = 1;
        sys525 = 0; fmt_wst = 0; h_start = '0; dv_delay = 4'd2;
        odd_first = 8'd0; odd_last = 8'd20; even_first = 8'd0; even_last = 8'd20;
        // R1: reset held while inputs would otherwise request.
        repeat (4) begin
            @(negedge clk);
            chk("R1", "ttx_req in reset", ttx_req, 1'b0);
            chk("R1", "data_valid in reset", data_valid, 1'b0);
            chk("R1", "line_active in reset", line_active, 1'b0);
        end
        vcount = '0; field_odd = 1;
        @(negedge clk);
        rst_n = 1;
        // 625-line windows: odd 4..7, even 11..14.
        run_phase("R2", "R6", 0, 0, 10, 5, 3, 7, 10, 14);
        // 525-line windows: odd 7..10, even 16..18.
        run_phase("R3", "R6", 1, 0, 12, 2, 3, 7, 12, 15);
        // Parity separation, world-standard length, longest delay.
        run_phase("R4", "R7", 0, 1, 30, 15, 0, 2, 18, 20);
        // Inverted windows in both fields, no requests.
        run_phase("R5", "R6", 0, 0, 5, 0, 9, 8, 5, 5);
        // 525: odd inverted (4 > 3), even single line 5; delay 0 clamps.
        run_phase("R5", "R7", 1, 1, 20, 0, 0, 0, 1, 2);
        // 625: start at column 0, delay 1 clamps, even covers lines 1..23.
        run_phase("R2", "R7", 0, 0, 0, 1, 1, 1, 0, 23);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule